// File: doc/BRIEF.md
# Nonvolatile Transfer Mode Controller

This block switches a small memory between two modes. In SRAM mode it serves ordinary reads and writes. In transfer mode it runs one of two whole-array copies. A store copies the SRAM into a nonvolatile shadow array. A recall copies the shadow array back into the SRAM. While either copy runs, the block is busy and no read or write reaches the SRAM.

A low-supply indication latches a pending recall. The recall is held back until a supply-good indication reports that the supply has recovered, and then it starts without further action. A store request comes from an external sequence detector as a single-cycle pulse. A pending recall always takes precedence over a store request, and a store request that loses this race is discarded.

Both transfers last a fixed number of clock cycles, set by parameters. A store first clears the shadow array and then programs it with the SRAM image at the end of its window. The two arrays are modelled as register arrays.

Top module: `nvtx_ctrl`

## Requirements
- R1: After synchronous reset, `busy` is 0, `xfer_mode` is 0 (SRAM mode), `recall_pending` is 0 and `rdata` is 0, and both arrays hold zero.
- R2: In SRAM mode, a write stores `wdata` at `addr` at the clock edge. A read drives `rdata` with the word at `addr` from the next edge on. A cycle without a read drives `rdata` to 0.
- R3: A `store_req` sampled in SRAM mode, with no pending recall and `low_supply` low, sets `xfer_mode` to 1 and `busy` to 1 for exactly STORE_CYC cycles. SRAM mode then resumes.
- R4: After a store completes, the shadow array holds a full copy of the SRAM taken at the end of the store window, and its previous contents are entirely replaced.
- R5: A cycle with `low_supply` high sets `recall_pending` from the next edge on, and it stays set until a recall starts.
- R6: A recall starts only from SRAM mode, with `recall_pending` set, `supply_good` high and `low_supply` low. Until then the pending request is held and SRAM access continues.
- R7: A recall sets `xfer_mode` to 2 and `busy` to 1 for exactly RESTORE_CYC cycles. It clears `recall_pending` and, when it ends, replaces every SRAM word with the corresponding shadow word.
- R8: While `busy` is high, a read returns 0 on `rdata` and a write leaves the SRAM unchanged.
- R9: A `store_req` while a recall is pending, or while `low_supply` is high, is dropped. It causes no store, either then or after the recall.
- R10: A `store_req` that arrives while a transfer is running is ignored. It does not extend or restart the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| low_supply | input | 1 | Supply is below the reset threshold |
| supply_good | input | 1 | Supply is above the switch threshold |
| store_req | input | 1 | Store request pulse from the sequence detector |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data, 0 when there is no valid read |
| busy | output | 1 | A transfer is running |
| xfer_mode | output | 2 | 0 = SRAM, 1 = store, 2 = recall |
| recall_pending | output | 1 | A latched recall is waiting for the supply to recover |

## Verification
The assertions assume that `store_req` is a synchronous pulse, that `low_supply` and `supply_good` are already synchronised to `clk`, and that both never report a good and a bad supply as true at the same time in a way that matters: the start rules treat `low_supply` as the stronger signal. The stimulus drives every input on the falling edge. It raises `supply_good` only after `low_supply` has dropped. It places store requests inside store windows, during a pending recall and in plain SRAM mode, so that each start rule is reached on its own.

// File: rtl/nvtx_pkg.sv
package nvtx_pkg;

    typedef enum logic [1:0] {
        XM_SRAM   = 2'd0,
        XM_STORE  = 2'd1,
        XM_RECALL = 2'd2
    } xfer_mode_e;

    typedef struct packed {
        logic erase;
        logic commit_store;
        logic commit_recall;
    } xfer_ctl_s;

    function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m < 2) ? 1 : $clog2(m);
    endfunction

endpackage

// File: rtl/nvtx_seq.sv
module nvtx_seq
    import nvtx_pkg::*;
#(
    parameter int unsigned STORE_CYC   = 20,
    parameter int unsigned RESTORE_CYC = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       low_supply,
    input  logic       supply_good,
    input  logic       store_req,
    output xfer_mode_e mode,
    output logic       pending,
    output xfer_ctl_s  ctl
);
    localparam int unsigned CNT_W = cnt_width(STORE_CYC, RESTORE_CYC);

    xfer_mode_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;
    logic             go_recall;
    logic             go_store;
    logic             last;

    always_comb begin
        go_recall = (state_q == XM_SRAM) && pend_q && supply_good && !low_supply;
        go_store  = (state_q == XM_SRAM) && store_req && !pend_q && !low_supply && !go_recall;
        last      = (state_q != XM_SRAM) && (cnt_q == '0);
        ctl.erase         = go_store;
        ctl.commit_store  = last && (state_q == XM_STORE);
        ctl.commit_recall = last && (state_q == XM_RECALL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= XM_SRAM;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            if (low_supply)     pend_q <= 1'b1;
            else if (go_recall) pend_q <= 1'b0;

            if (go_recall) begin
                state_q <= XM_RECALL;
                cnt_q   <= CNT_W'(RESTORE_CYC - 1);
            end else if (go_store) begin
                state_q <= XM_STORE;
                cnt_q   <= CNT_W'(STORE_CYC - 1);
            end else if (last) begin
                state_q <= XM_SRAM;
            end else if (state_q != XM_SRAM) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign mode    = state_q;
    assign pending = pend_q;

endmodule

// File: rtl/nvtx_mem.sv
module nvtx_mem
    import nvtx_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  xfer_ctl_s         ctl,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic              wr_ok;
    logic [DATA_W-1:0] word_vec [DEPTH];

    assign wr_ok = wr_en && !busy;

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        logic [DATA_W-1:0] sram_q;
        logic [DATA_W-1:0] nv_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sram_q <= '0;
                nv_q   <= '0;
            end else begin
                if (ctl.commit_recall)
                    sram_q <= nv_q;
                else if (wr_ok && (addr == ADDR_W'(w)))
                    sram_q <= wdata;

                if (ctl.erase)
                    nv_q <= '0;
                else if (ctl.commit_store)
                    nv_q <= sram_q;
            end
        end

        assign word_vec[w] = sram_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en && !busy)
            rdata <= word_vec[addr];
        else
            rdata <= '0;
    end

endmodule

// File: rtl/nvtx_ctrl.sv
module nvtx_ctrl
    import nvtx_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned STORE_CYC   = 20,
    parameter int unsigned RESTORE_CYC = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              low_supply,
    input  logic              supply_good,
    input  logic              store_req,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy,
    output logic [1:0]        xfer_mode,
    output logic              recall_pending
);
    xfer_mode_e mode;
    xfer_ctl_s  ctl;

    nvtx_seq #(
        .STORE_CYC  (STORE_CYC),
        .RESTORE_CYC(RESTORE_CYC)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .low_supply (low_supply),
        .supply_good(supply_good),
        .store_req  (store_req),
        .mode       (mode),
        .pending    (recall_pending),
        .ctl        (ctl)
    );

    assign busy      = (mode != XM_SRAM);
    assign xfer_mode = mode;

    nvtx_mem #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_mem (
        .clk  (clk),
        .rst  (rst),
        .busy (busy),
        .rd_en(rd_en),
        .wr_en(wr_en),
        .addr (addr),
        .wdata(wdata),
        .ctl  (ctl),
        .rdata(rdata)
    );

endmodule

// File: rtl/nvtx_ctrl_chk.sv
module nvtx_ctrl_chk #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned STORE_CYC   = 20,
    parameter int unsigned RESTORE_CYC = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              low_supply,
    input logic              supply_good,
    input logic              store_req,
    input logic              busy,
    input logic [1:0]        xfer_mode,
    input logic              recall_pending,
    input logic [DATA_W-1:0] rdata
);
    int unsigned st_run_q;
    int unsigned rc_run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_run_q <= 0;
            rc_run_q <= 0;
        end else begin
            st_run_q <= (xfer_mode == 2'd1) ? st_run_q + 1 : 0;
            rc_run_q <= (xfer_mode == 2'd2) ? rc_run_q + 1 : 0;
        end
    end

    // R3: a store window lasts exactly STORE_CYC cycles
    assert_store_len_R3: assert property (@(posedge clk) disable iff (rst)
        (xfer_mode != 2'd1 && st_run_q != 0) |-> st_run_q == STORE_CYC);

    // R3: a clean store request starts a store
    assert_store_start_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy && store_req && !recall_pending && !low_supply) |=> xfer_mode == 2'd1);

    // R7: a recall window lasts exactly RESTORE_CYC cycles
    assert_recall_len_R7: assert property (@(posedge clk) disable iff (rst)
        (xfer_mode != 2'd2 && rc_run_q != 0) |-> rc_run_q == RESTORE_CYC);

    // R5: low supply latches a pending recall
    assert_pend_latch_R5: assert property (@(posedge clk) disable iff (rst)
        low_supply |=> recall_pending);

    // R6: a recall only begins once the supply is good and a request is pending
    assert_recall_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy ##1 xfer_mode == 2'd2) |-> ($past(supply_good) && $past(recall_pending)));

    // R8: reads during a transfer return zero
    assert_busy_rdata_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> rdata == '0);

    // R9: a pending recall beats a simultaneous store request
    assert_recall_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && store_req && recall_pending && supply_good && !low_supply) |=> xfer_mode == 2'd2);

    // R10: a store window never turns directly into a recall
    assert_store_exit_R10: assert property (@(posedge clk) disable iff (rst)
        (xfer_mode == 2'd1) |=> (xfer_mode != 2'd2));

endmodule

bind nvtx_ctrl nvtx_ctrl_chk #(
    .DATA_W     (DATA_W),
    .STORE_CYC  (STORE_CYC),
    .RESTORE_CYC(RESTORE_CYC)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .low_supply    (low_supply),
    .supply_good   (supply_good),
    .store_req     (store_req),
    .busy          (busy),
    .xfer_mode     (xfer_mode),
    .recall_pending(recall_pending),
    .rdata         (rdata)
);

// File: tb/nvtx_ctrl_tb.sv
module nvtx_ctrl_tb;
    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int SCYC  = 20;
    localparam int RCYC  = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          low_supply = 1'b0;
    logic          supply_good = 1'b1;
    logic          store_req = 1'b0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          busy;
    logic [1:0]    xfer_mode;
    logic          recall_pending;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    nvtx_ctrl #(.ADDR_W(AW), .DATA_W(DW), .STORE_CYC(SCYC), .RESTORE_CYC(RCYC)) u_dut (
        .clk(clk), .rst(rst), .low_supply(low_supply), .supply_good(supply_good),
        .store_req(store_req), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .busy(busy), .xfer_mode(xfer_mode),
        .recall_pending(recall_pending)
    );

    // behavioural reference model
    int          m_mode = 0;
    int          m_left = 0;
    bit          m_pend = 0;
    logic [DW-1:0] m_rdata = '0;
    logic [DW-1:0] m_sram [DEPTH];
    logic [DW-1:0] m_nv   [DEPTH];

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_left = 0; m_pend = 0; m_rdata = '0;
            for (int i = 0; i < DEPTH; i++) begin m_sram[i] = '0; m_nv[i] = '0; end
        end else begin
            bit idle, pend_old;
            idle     = (m_mode == 0);
            pend_old = m_pend;
            m_rdata  = (rd_en && idle) ? m_sram[addr] : '0;
            if (wr_en && idle) m_sram[addr] = wdata;
            if (low_supply) m_pend = 1;
            if (idle) begin
                if (pend_old && supply_good && !low_supply) begin
                    m_mode = 2; m_left = RCYC; m_pend = 0;
                end else if (store_req && !pend_old && !low_supply) begin
                    m_mode = 1; m_left = SCYC;
                end
            end else begin
                m_left--;
                if (m_left == 0) begin
                    if (m_mode == 1) for (int i = 0; i < DEPTH; i++) m_nv[i] = m_sram[i];
                    else             for (int i = 0; i < DEPTH; i++) m_sram[i] = m_nv[i];
                    m_mode = 0;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // compare against the model on every falling edge
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            check(busy == (m_mode != 0), "R3 busy", busy, m_mode != 0);
            check(xfer_mode == 2'(m_mode), "R7 mode", xfer_mode, m_mode);
            check(recall_pending == m_pend, "R5 pending", recall_pending, m_pend);
            check(rdata == m_rdata, "R2/R8 rdata", rdata, m_rdata);
        end
    end

    // watchdog
    always @(negedge clk) begin
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [DW-1:0] pat(input int i);
        return DW'((i * 37 + 11) ^ 8'h5A);
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        wr_en = 1'b1; addr = AW'(a); wdata = d; tick(); wr_en = 1'b0;
    endtask

    task automatic rd_check(input int a, input logic [DW-1:0] exp, input string req);
        rd_en = 1'b1; addr = AW'(a); tick(); rd_en = 1'b0;
        check(rdata == exp, req, rdata, exp);
    endtask

    task automatic wait_idle();
        while (busy) tick();
    endtask

    initial begin
        repeat (3) tick();
        // R1: reset state
        check(busy == 1'b0 && xfer_mode == 2'd0 && recall_pending == 1'b0 && rdata == '0,
              "R1 reset", {busy, xfer_mode, recall_pending}, 0);
        rst = 1'b0;
        tick();

        // R2: fill and read back
        for (int i = 0; i < DEPTH; i++) wr(i, pat(i));
        rd_check(3, pat(3), "R2 read");
        rd_check(15, pat(15), "R2 read");
        tick();
        check(rdata == '0, "R2 idle rdata", rdata, 0);

        // R3: store; R8 and R10 during the store window
        store_req = 1'b1; tick(); store_req = 1'b0;
        check(busy == 1'b1 && xfer_mode == 2'd1, "R3 store start", xfer_mode, 1);
        wr(0, 8'hEE);
        rd_check(0, 8'h00, "R8 read while busy");
        repeat (5) tick();
        store_req = 1'b1; tick(); store_req = 1'b0;   // R10
        wait_idle();
        rd_check(0, pat(0), "R8 write ignored while busy");

        // corrupt the SRAM
        for (int i = 0; i < DEPTH; i++) wr(i, ~pat(i));
        rd_check(5, ~pat(5), "R2 corrupt");

        // R5/R6: low supply latches a recall, held while supply is bad
        supply_good = 1'b0; low_supply = 1'b1; tick(); tick(); low_supply = 1'b0;
        check(recall_pending == 1'b1, "R5 latch", recall_pending, 1);
        repeat (6) tick();
        check(busy == 1'b0, "R6 held", busy, 0);
        rd_check(5, ~pat(5), "R6 access while pending");
        // R9: store request while pending is dropped
        store_req = 1'b1; tick(); store_req = 1'b0;
        check(busy == 1'b0, "R9 store dropped", busy, 0);

        // R7: recall once supply is good
        supply_good = 1'b1; tick();
        check(xfer_mode == 2'd2 && recall_pending == 1'b0, "R7 recall start", xfer_mode, 2);
        wait_idle();
        for (int i = 0; i < DEPTH; i++) rd_check(i, pat(i), "R7 restored word");
        check(busy == 1'b0, "R9 no late store", busy, 0);

        // R4: a second store replaces the shadow; recall proves it
        for (int i = 0; i < DEPTH; i++) wr(i, DW'(i + 8'hA0));
        store_req = 1'b1; tick(); store_req = 1'b0;
        // R5: low supply during store queues a recall behind it
        low_supply = 1'b1; supply_good = 1'b0; tick(); low_supply = 1'b0;
        wait_idle();
        check(recall_pending == 1'b1, "R5 queued behind store", recall_pending, 1);
        for (int i = 0; i < DEPTH; i++) wr(i, 8'h00);
        // R9: store and pending recall together -> recall wins
        supply_good = 1'b1; store_req = 1'b1; tick(); store_req = 1'b0;
        check(xfer_mode == 2'd2, "R9 recall wins", xfer_mode, 2);
        wait_idle();
        for (int i = 0; i < DEPTH; i++) rd_check(i, DW'(i + 8'hA0), "R4 shadow replaced");

        repeat (3) tick();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule